// File: doc/BRIEF.md
# Protected System Clock Prescaler

This block divides the system clock by a programmable power of two, from 1 up to 256, and emits the result as a one-cycle clock-enable pulse. Logic that runs at the slower rate qualifies its registers with that pulse. The divide factor is held in a single byte-wide control register. After reset the factor comes from a fuse input: divide-by-8 when the fuse is programmed, divide-by-1 when it is not.

A timed unlock sequence protects the factor from stray writes. Software first writes the unlock bit on its own. It must then write the new code within the next four clock cycles. A write outside that window changes nothing. A reserved code closes the window and also changes nothing. A code that is accepted replaces the running factor only when the current output period ends, so no output period is ever shorter than either factor.

Top module: `clk_prescaler`

## Requirements
- R1: The reset is synchronous and active low. While it is held, the divider code loads 3 (factor 8) when `fuse_div8` is 1 and 0 (factor 1) when it is 0. The unlock window is closed at reset.
- R2: A write whose bit 7 is 1 and whose bits 3:0 are all 0 is an unlock write. It opens the window, and read bit 7 reads 1 from the next cycle.
- R3: A write that is not an unlock write and arrives on the first, second, third or fourth clock edge after the unlock edge sets the divider code to bits 3:0 if that value is 0 to 8. The write closes the window.
- R4: If no write arrives on those four edges, the window closes by itself. A write on the fifth edge or later leaves the code unchanged.
- R5: A non-unlock write made while the window is closed leaves the whole read value unchanged.
- R6: A write of a reserved code (9 to 15) inside the window leaves the code unchanged and closes the window.
- R7: `clk_en` is high for one cycle in every 2^code cycles. With code 0 it is high on every cycle.
- R8: A new code takes effect only at the next `clk_en` pulse. The period already running finishes at the old factor.
- R9: Read data is {window open, 3'b000, code[3:0]}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| fuse_div8 | input | 1 | Reset-default selector: 1 gives factor 8, 0 gives factor 1 |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| rd_data | output | 8 | Control register read value |
| clk_en | output | 1 | Divided clock-enable pulse |

## Verification
A wrong window count shows up in the read value's bit 7 one cycle after the unlock write. It also shows up as an accepted or refused write on the fourth or fifth edge, and the read value reports that on the next cycle. A corrupted divider counter or running factor first shows as a wrong gap between `clk_en` pulses, which can take up to 256 cycles to appear. An early factor swap shortens the period in which the change is made. The bench therefore measures pulse gaps across each factor change as well as in the steady state.

// File: rtl/clk_prescaler.sv
module clk_prescaler #(
  parameter int DATA_W    = 8,
  parameter int CODE_W    = 4,
  parameter int MAX_CODE  = 8,
  parameter int WIN_CYC   = 4,
  parameter int FUSE_CODE = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fuse_div8,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              clk_en
);
  localparam int CNT_W = MAX_CODE;
  localparam int WIN_W = $clog2(WIN_CYC + 1);
  localparam logic [CODE_W-1:0] RST_CODE = CODE_W'(FUSE_CODE);

  logic [CODE_W-1:0] reg_code, act_code;
  logic [CNT_W-1:0]  cnt, lim;
  logic [CNT_W:0]    fac;
  logic [WIN_W-1:0]  win_cnt;

  wire win_open = win_cnt != '0;
  wire unlk_wr  = wr_en && wr_data[DATA_W-1] && (wr_data[CODE_W-1:0] == '0);
  wire data_wr  = wr_en && !unlk_wr && win_open;
  wire code_ok  = wr_data[CODE_W-1:0] <= CODE_W'(MAX_CODE);

  always_ff @(posedge clk) begin
    if (!rst_n)        win_cnt <= '0;
    else if (unlk_wr)  win_cnt <= WIN_W'(WIN_CYC);
    else if (data_wr)  win_cnt <= '0;
    else if (win_open) win_cnt <= win_cnt - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                  reg_code <= fuse_div8 ? RST_CODE : '0;
    else if (data_wr && code_ok) reg_code <= wr_data[CODE_W-1:0];
  end

  assign fac    = {{CNT_W{1'b0}}, 1'b1} << act_code;
  assign lim    = CNT_W'(fac - 1'b1);
  assign clk_en = cnt == lim;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      act_code <= fuse_div8 ? RST_CODE : '0;
    end else if (clk_en) begin
      cnt      <= '0;
      act_code <= reg_code;
    end else begin
      cnt      <= cnt + 1'b1;
    end
  end

  assign rd_data = {win_open, {(DATA_W-CODE_W-1){1'b0}}, reg_code};
endmodule

// File: rtl/clk_prescaler_chk.sv
module clk_prescaler_chk #(
  parameter int DATA_W   = 8,
  parameter int CODE_W   = 4,
  parameter int MAX_CODE = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fuse_div8,
  input logic              wr_en,
  input logic [DATA_W-1:0] wr_data,
  input logic [DATA_W-1:0] rd_data,
  input logic              clk_en
);
  localparam int GAP_W = MAX_CODE + 2;
  logic [GAP_W-1:0] gap, want;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap  <= '0;
      want <= fuse_div8 ? GAP_W'(8) : GAP_W'(1);
    end else if (clk_en) begin
      gap  <= '0;
      want <= GAP_W'(1) << rd_data[CODE_W-1:0];
    end else begin
      gap  <= gap + 1'b1;
    end
  end

  wire unlk = wr_en && wr_data[DATA_W-1] && (wr_data[CODE_W-1:0] == '0);

  p_unlock_opens_r2: assert property (@(posedge clk) disable iff (!rst_n)
    unlk |=> rd_data[DATA_W-1]);
  p_write_closes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlk && rd_data[DATA_W-1]) |=> !rd_data[DATA_W-1]);
  p_locked_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !unlk && !rd_data[DATA_W-1]) |=> $stable(rd_data));
  p_code_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[CODE_W-1:0] <= CODE_W'(MAX_CODE));
  p_period_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clk_en |-> (gap + 1'b1 == want));
  p_pad_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data[DATA_W-2:CODE_W] == '0);
endmodule

bind clk_prescaler clk_prescaler_chk #(
  .DATA_W(DATA_W), .CODE_W(CODE_W), .MAX_CODE(MAX_CODE)
) u_chk (.*);

// File: tb/tb_clk_prescaler.sv
module tb_clk_prescaler;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fuse_div8 = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [7:0] rd_data;
  logic       clk_en;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  clk_prescaler dut (.*);

  localparam int NV = 12;
  localparam logic [3:0] V_WR [NV] = '{4'd2, 4'd0, 4'd5, 4'd9, 4'd1, 4'd8,
                                       4'd15, 4'd3, 4'd6, 4'd4, 4'd12, 4'd7};
  localparam logic [3:0] V_EX [NV] = '{4'd2, 4'd0, 4'd5, 4'd5, 4'd1, 4'd8,
                                       4'd8, 4'd3, 4'd6, 4'd4, 4'd4, 4'd7};

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wait_pulse();
    forever begin
      @(negedge clk);
      if (clk_en) break;
    end
  endtask

  task automatic period(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!clk_en);
  endtask

  task automatic do_reset(input logic f);
    @(negedge clk);
    rst_n = 1'b0; fuse_div8 = f;
    idle(3);
    rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_bad++; n_chk++;
        $display("FAIL watchdog: actual %0d expected below 150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end

  initial begin
    int p;
    do_reset(1'b0);
    check("R1 reset fuse0 read", rd_data, 8'h00);
    period(p); check("R7 factor1 period", p, 1);
    check("R7 factor1 clk_en", clk_en, 1);

    do_reset(1'b1);
    check("R1 reset fuse1 read", rd_data, 8'h03);
    wait_pulse(); period(p); check("R1 reset fuse1 period", p, 8);

    for (int k = 0; k < NV; k++) begin
      do_wr(8'h80);
      check("R2 window open", rd_data[7], 1);
      do_wr({4'h0, V_WR[k]});
      check("R3 R6 code", rd_data, {4'h0, V_EX[k]});
      wait_pulse(); wait_pulse();
      period(p); check("R7 period", p, 1 << V_EX[k]);
    end

    do_wr(8'h80);
    do_wr(8'h02);
    do_wr(8'h04);
    check("R5 locked write ignored", rd_data, 8'h02);

    do_wr(8'h80); idle(3); do_wr(8'h03);
    check("R3 fourth edge accepted", rd_data, 8'h03);

    do_wr(8'h80); idle(3);
    check("R4 window still open", rd_data[7], 1);
    idle(1);
    check("R4 window expired", rd_data, 8'h03);
    do_wr(8'h01);
    check("R4 late write ignored", rd_data, 8'h03);

    do_wr(8'h80); do_wr(8'h0A);
    check("R6 reserved closes window", rd_data, 8'h03);
    do_wr(8'h01);
    check("R6 following write ignored", rd_data, 8'h03);

    do_wr(8'h80); do_wr(8'h04);
    wait_pulse(); wait_pulse();
    do_wr(8'h80); do_wr(8'h00);
    p = 2;
    do begin @(negedge clk); p++; end while (!clk_en);
    check("R8 old period completes", p, 16);
    period(p); check("R8 new factor after boundary", p, 1);

    do_wr(8'h80); do_wr(8'h08);
    wait_pulse();
    do_wr(8'h80); do_wr(8'h01);
    p = 2;
    do begin @(negedge clk); p++; end while (!clk_en);
    check("R8 long period completes", p, 256);
    period(p); check("R8 shorter factor applied", p, 2);

    do_wr(8'h80);
    check("R9 read format open", rd_data, 8'h81);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule